// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block sits next to a processor core and records two board-level configuration straps during system reset. One is a multi-bit bus-to-core clock ratio select. The other is a single-bit enable for the on-chip interrupt controller. The core reads both from the block's outputs once reset has been released.

The block times every assertion of the system reset input. A reset that lasts at least one millisecond counts as cold, and only a cold reset may load a new clock ratio. A shorter, warm reset keeps the ratio that was loaded earlier. The interrupt-enable strap is reloaded on every reset release, whatever the length of the reset. The block also watches the ratio strap for as long as reset is asserted, and it raises a sticky fault flag if the strap moves during that window.

A separate power-on reset puts parameterised default values in place before any cold reset has finished.

Top module: `strap_cfg_latch`

## Requirements
- R1: While `por_rst` is high at a clock edge, after that edge `core_ratio` equals `DEFAULT_RATIO`, `core_irq_en` equals `DEFAULT_IRQ` and `strap_fault` is 0.
- R2: If `sys_rst` is sampled high on at least `HOLD_CLKS` consecutive clock edges and then sampled low, then after the first low edge `core_ratio` holds the `ratio_strap` value sampled on the last high edge.
- R3: If `sys_rst` is sampled high on fewer than `HOLD_CLKS` consecutive edges (a warm reset), then `core_ratio` keeps its previous value across the release.
- R4: `core_ratio` changes only after the first edge at which `sys_rst` is sampled low following a cold reset. It is stable while reset is held and during normal operation.
- R5: On every reset release, after the first edge at which `sys_rst` is sampled low, `core_irq_en` equals the `irq_strap` level sampled at that same edge (1 = controller enabled, 0 = disabled). Both warm and cold resets do this.
- R6: Apart from the release edge, `irq_strap` has no effect: `core_irq_en` stays unchanged.
- R7: If, while `sys_rst` stays high, `ratio_strap` is sampled with a value different from its value on the first high edge of that assertion, then `strap_fault` is 1 after that edge.
- R8: `strap_fault` is sticky. It stays 1 after reset is released, and it is cleared only by the first high edge of the next `sys_rst` assertion or by `por_rst`.
- R9: The cold/warm boundary is exact: a hold of exactly `HOLD_CLKS` sampled-high edges is cold, and a hold of `HOLD_CLKS`-1 edges is warm.
- R10: Changes on `ratio_strap` while `sys_rst` is low never set `strap_fault` and never change `core_ratio`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset; loads the defaults |
| sys_rst | input | 1 | System reset being timed and used for strap capture (active high) |
| ratio_strap | input | 3 | Clock-ratio strap pins |
| irq_strap | input | 1 | Interrupt-controller enable strap pin |
| core_ratio | output | 3 | Latched clock-ratio select |
| core_irq_en | output | 1 | Latched interrupt-controller enable |
| strap_fault | output | 1 | Sticky flag: ratio strap moved during the current or last reset |

## Verification
The bench builds the block with `HOLD_CLKS` set to 8, which stands for one millisecond. This puts both sides of the cold/warm boundary within a handful of cycles, so resets of 7, 8 and 20 cycles can be compared directly. `DEFAULT_RATIO` is set to 3'b101 so that the power-on value differs from every ratio loaded later; a missed or premature load then shows up at the outputs. Resets with a one-cycle strap glitch in the middle are mixed with clean ones so that the sticky fault flag can be seen to set and then clear.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;

    localparam int RATIO_W = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t ratio;
        logic   irq_en;
    } strap_cfg_t;

    typedef struct packed {
        logic rise;   // first edge of an assertion
        logic held;   // assertion continues
        logic fall;   // first edge after release
    } rst_phase_t;

    function automatic rst_phase_t decode_phase(input logic now, input logic prev);
        rst_phase_t p;
        p.rise = now & ~prev;
        p.held = now & prev;
        p.fall = ~now & prev;
        return p;
    endfunction

endpackage

// File: rtl/strap_hold_timer.sv
module strap_hold_timer
    import strap_latch_pkg::*;
#(
    parameter int HOLD_CLKS = 66000
) (
    input  logic       clk,
    input  logic       por_rst,
    input  logic       rst_now,
    output logic       cold_hold
);
    localparam int CNT_W = $clog2(HOLD_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CLKS);

    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            hold_cnt <= '0;
        end else if (!rst_now) begin
            hold_cnt <= '0;
        end else if (hold_cnt != LIMIT) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Saturated count means the assertion lasted long enough to be cold.
    assign cold_hold = (hold_cnt == LIMIT);

endmodule

// File: rtl/strap_ratio_monitor.sv
module strap_ratio_monitor
    import strap_latch_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  rst_phase_t phase,
    input  ratio_t     ratio_pin,
    output ratio_t     held_ratio,
    output logic       moved
);
    ratio_t first_q;
    ratio_t last_q;
    logic   moved_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            first_q <= '0;
            last_q  <= '0;
            moved_q <= 1'b0;
        end else if (phase.rise) begin
            first_q <= ratio_pin;
            last_q  <= ratio_pin;
            moved_q <= 1'b0;
        end else if (phase.held) begin
            last_q <= ratio_pin;
            if (ratio_pin != first_q) begin
                moved_q <= 1'b1;
            end
        end
    end

    assign held_ratio = last_q;
    assign moved      = moved_q;

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
    import strap_latch_pkg::*;
#(
    parameter int     HOLD_CLKS     = 66000,
    parameter ratio_t DEFAULT_RATIO = 3'b001,
    parameter bit     DEFAULT_IRQ   = 1'b0
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic               sys_rst,
    input  logic [RATIO_W-1:0] ratio_strap,
    input  logic               irq_strap,
    output logic [RATIO_W-1:0] core_ratio,
    output logic               core_irq_en,
    output logic               strap_fault
);
    logic       rst_q;
    rst_phase_t phase;
    logic       cold_hold;
    ratio_t     held_ratio;
    strap_cfg_t cfg_q;

    assign phase = decode_phase(sys_rst, rst_q);

    strap_hold_timer #(
        .HOLD_CLKS (HOLD_CLKS)
    ) u_timer (
        .clk       (clk),
        .por_rst   (por_rst),
        .rst_now   (sys_rst),
        .cold_hold (cold_hold)
    );

    strap_ratio_monitor u_mon (
        .clk        (clk),
        .por_rst    (por_rst),
        .phase      (phase),
        .ratio_pin  (ratio_strap),
        .held_ratio (held_ratio),
        .moved      (strap_fault)
    );

    always_ff @(posedge clk) begin
        if (por_rst) begin
            rst_q        <= 1'b0;
            cfg_q.ratio  <= DEFAULT_RATIO;
            cfg_q.irq_en <= DEFAULT_IRQ;
        end else begin
            rst_q <= sys_rst;
            if (phase.fall) begin
                cfg_q.irq_en <= irq_strap;
                if (cold_hold) begin
                    cfg_q.ratio <= held_ratio;
                end
            end
        end
    end

    assign core_ratio  = cfg_q.ratio;
    assign core_irq_en = cfg_q.irq_en;

endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk
    import strap_latch_pkg::*;
#(
    parameter int     HOLD_CLKS     = 66000,
    parameter ratio_t DEFAULT_RATIO = 3'b001,
    parameter bit     DEFAULT_IRQ   = 1'b0
) (
    input logic               clk,
    input logic               por_rst,
    input logic               sys_rst,
    input logic [RATIO_W-1:0] ratio_strap,
    input logic               irq_strap,
    input logic [RATIO_W-1:0] core_ratio,
    input logic               core_irq_en,
    input logic               strap_fault
);
    localparam int CNT_W = $clog2(HOLD_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CLKS);

    logic [CNT_W-1:0] ref_cnt;
    ratio_t           ref_last;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ref_cnt  <= '0;
            ref_last <= '0;
        end else if (sys_rst) begin
            ref_last <= ratio_strap;
            if (ref_cnt != LIMIT) ref_cnt <= ref_cnt + 1'b1;
        end else begin
            ref_cnt <= '0;
        end
    end

    AST_POR_DEFAULTS: assert property (@(posedge clk)
        por_rst |=> (core_ratio == DEFAULT_RATIO && core_irq_en == DEFAULT_IRQ && !strap_fault)); // R1

    AST_COLD_LOADS_RATIO: assert property (@(posedge clk) disable iff (por_rst)
        ($fell(sys_rst) && ref_cnt == LIMIT) |=> (core_ratio == $past(ref_last))); // R2

    AST_WARM_KEEPS_RATIO: assert property (@(posedge clk) disable iff (por_rst)
        ($fell(sys_rst) && ref_cnt != LIMIT) |=> $stable(core_ratio)); // R3

    AST_RATIO_STABLE_ELSEWHERE: assert property (@(posedge clk) disable iff (por_rst)
        !$fell(sys_rst) |=> $stable(core_ratio)); // R4

    AST_IRQ_AT_RELEASE: assert property (@(posedge clk) disable iff (por_rst)
        $fell(sys_rst) |=> (core_irq_en == $past(irq_strap))); // R5

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (por_rst)
        !$fell(sys_rst) |=> $stable(core_irq_en)); // R6

    AST_FAULT_ON_MOVE: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && $past(sys_rst) && !$stable(ratio_strap)) |=> strap_fault); // R7

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (por_rst)
        $rose(sys_rst) |=> !strap_fault); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        (strap_fault && !sys_rst) |=> strap_fault); // R8

    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (por_rst)
        (!sys_rst && !strap_fault) |=> !strap_fault); // R10

endmodule

bind strap_cfg_latch strap_latch_chk #(
    .HOLD_CLKS     (HOLD_CLKS),
    .DEFAULT_RATIO (DEFAULT_RATIO),
    .DEFAULT_IRQ   (DEFAULT_IRQ)
) u_chk (
    .clk         (clk),
    .por_rst     (por_rst),
    .sys_rst     (sys_rst),
    .ratio_strap (ratio_strap),
    .irq_strap   (irq_strap),
    .core_ratio  (core_ratio),
    .core_irq_en (core_irq_en),
    .strap_fault (strap_fault)
);

// File: tb/tb_strap_cfg_latch.sv
module tb_strap_cfg_latch;

    localparam int         CLK_PERIOD = 10;
    localparam int         HOLD       = 8;
    localparam logic [2:0] DEF_RATIO  = 3'b101;
    localparam int         NVEC       = 8;

    // {hold cycles, ratio strap, irq strap, glitch, exp ratio, exp irq, exp fault}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'd8,  3'b010, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0},  // R2 R9 exact threshold
        {8'd7,  3'b110, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0},  // R3 R9 one short
        {8'd12, 3'b111, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1},  // R7 glitch, cold
        {8'd3,  3'b000, 1'b1, 1'b0, 3'b111, 1'b1, 1'b0},  // R3 R8 warm, fault cleared
        {8'd20, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0},  // R2 long hold
        {8'd4,  3'b011, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1},  // R3 R7 warm with glitch
        {8'd9,  3'b100, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0},  // R2 R8
        {8'd10, 3'b001, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1}   // R7 R8 before power-on reset
    };

    logic       clk = 1'b0;
    logic       por_rst;
    logic       sys_rst;
    logic [2:0] ratio_strap;
    logic       irq_strap;
    logic [2:0] core_ratio;
    logic       core_irq_en;
    logic       strap_fault;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strap_cfg_latch #(
        .HOLD_CLKS     (HOLD),
        .DEFAULT_RATIO (DEF_RATIO),
        .DEFAULT_IRQ   (1'b0)
    ) dut (
        .clk         (clk),
        .por_rst     (por_rst),
        .sys_rst     (sys_rst),
        .ratio_strap (ratio_strap),
        .irq_strap   (irq_strap),
        .core_ratio  (core_ratio),
        .core_irq_en (core_irq_en),
        .strap_fault (strap_fault)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one reset assertion starting at a negedge; returns at the negedge after release.
    task automatic run_reset(input int hold, input logic [2:0] rv, input logic iv,
                             input logic glitch, input logic [2:0] prev_ratio);
        sys_rst   = 1'b1;
        irq_strap = ~iv;
        for (int i = 0; i < hold; i++) begin
            ratio_strap = (glitch && i == hold / 2) ? ~rv : rv;
            @(posedge clk);
            @(negedge clk);
            if (i == 0) check("R8 fault cleared at assertion", int'(strap_fault), 0);
            check("R4 ratio stable during hold", int'(core_ratio), int'(prev_ratio));
        end
        ratio_strap = rv;
        sys_rst     = 1'b0;
        irq_strap   = iv;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        por_rst     = 1'b1;
        sys_rst     = 1'b0;
        ratio_strap = 3'b000;
        irq_strap   = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 ratio default", int'(core_ratio), int'(DEF_RATIO));
        check("R1 irq default", int'(core_irq_en), 0);
        check("R1 fault clear", int'(strap_fault), 0);
        por_rst = 1'b0;

        // R10: strap wiggles with reset low do nothing
        for (int k = 0; k < 4; k++) begin
            ratio_strap = 3'(k * 3);
            irq_strap   = k[0];
            @(posedge clk);
            @(negedge clk);
        end
        check("R10 ratio unchanged while idle", int'(core_ratio), int'(DEF_RATIO));
        check("R10 no fault while idle", int'(strap_fault), 0);
        check("R6 irq unchanged while idle", int'(core_irq_en), 0);

        begin
            logic [2:0] prev = DEF_RATIO;
            for (int v = 0; v < NVEC; v++) begin
                logic [17:0] e = VEC[v];
                run_reset(int'(e[17:10]), e[9:7], e[6], e[5], prev);
                check("R2/R3 ratio after release", int'(core_ratio), int'(e[4:2]));
                check("R5 irq at release", int'(core_irq_en), int'(e[1]));
                check("R7/R8 fault after release", int'(strap_fault), int'(e[0]));
                // R6 R10: idle wiggles after release
                for (int k = 0; k < 3; k++) begin
                    ratio_strap = ~e[9:7] ^ 3'(k);
                    irq_strap   = ~e[6];
                    @(posedge clk);
                    @(negedge clk);
                end
                check("R6 irq held after release", int'(core_irq_en), int'(e[1]));
                check("R10 ratio held after release", int'(core_ratio), int'(e[4:2]));
                check("R8 fault sticky after release", int'(strap_fault), int'(e[0]));
                prev = e[4:2];
            end
        end

        // R1: power-on reset mid-operation restores defaults
        por_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        por_rst = 1'b0;
        check("R1 ratio default after por", int'(core_ratio), int'(DEF_RATIO));
        check("R1 irq default after por", int'(core_irq_en), 0);
        check("R1 fault clear after por", int'(strap_fault), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule